// File: doc/BRIEF.md
# Latency-Class Issue Scoreboard

This block sits at the issue stage of an in-order pipeline. It decides, one instruction per cycle, whether the instruction offered by decode may issue now. Each general register that a tracked instruction writes gets a small countdown. The countdown is loaded at issue with a value that depends on the producer's operation class, so a dependent consumer is held for exactly the producer's result latency. Multiply-class work goes to a separate multiply unit, which interlocks on its own, so it leaves no entry here.

The fields of the control/status register are scoreboarded as separate pseudo-registers, so single-field producers and consumers only interlock on the field they name. An access that spans more than one field cannot be tracked per field and is serialized against graduation instead. A multi-field read waits until nothing older is in flight. A multi-field write blocks every younger instruction until it has graduated. An in-flight counter, stepped by issue and by graduation pulses, provides the drain condition.

The issue port uses a valid/ready handshake. `iss_ready` is computed combinationally from the offered payload and the held state, and it may be low while `iss_valid` is low. An instruction issues only in a cycle where both are high. Decode must hold the payload stable while it is refused. A refused offer changes no state.

Top module: `issue_scoreboard`

## Requirements
- R1: An instruction issues only in a cycle where `iss_valid` and `iss_ready` are both high. A refused offer leaves the busy vectors and the in-flight count unchanged.
- R2: Class code 0 (simple logic, move, short shift, compare-set, sign-extend) writing register d leaves d not busy, so a consumer of d may issue in the very next cycle.
- R3: Class code 1 (plain arithmetic or simple packed arithmetic) writing register d marks d busy for one cycle after issue, so a consumer of d may issue two cycles after the producer.
- R4: Class code 2 (packed arithmetic with saturation or rounding) writing register d marks d busy for two cycles after issue, so a consumer of d may issue three cycles after the producer.
- R5: Class code 3 (multiply/divide, handed to the separate unit) never marks its destination busy.
- R6: Register 0 is never busy, and a source tag of 0 never stalls issue.
- R7: A write whose field-write mask has exactly one bit set marks only that field busy, with the latency of its class. A read whose field-read mask has exactly one bit set stalls only while that field is busy.
- R8: A read whose field-read mask has two or more bits set is refused until the in-flight count is zero.
- R9: After a write whose field-write mask has two or more bits set issues, `iss_ready` stays low until the cycle after the in-flight count returns to zero. A single-bit field write causes no such hold.
- R10: The 4-bit in-flight count rises by one per issue and falls by one per graduation pulse. It is unchanged when both occur together. A pulse at count zero is ignored. At count 15, `iss_ready` is low.
- R11: After reset, both busy vectors and the in-flight count are zero, and `iss_ready` is high for a hazard-free offer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_ready | output | 1 | The offered instruction may issue this cycle |
| iss_cls | input | 2 | Operation class code (0 simple, 1 arith, 2 sat/round, 3 multiply) |
| iss_src0 | input | 5 | First source register tag |
| iss_src1 | input | 5 | Second source register tag |
| iss_dst | input | 5 | Destination register tag |
| iss_dst_we | input | 1 | The instruction writes `iss_dst` |
| iss_frd | input | 4 | Control-register fields read, one bit per field |
| iss_fwr | input | 4 | Control-register fields written, one bit per field |
| grad | input | 1 | One older instruction graduates this cycle |
| reg_busy | output | 32 | Per-register pending-result flags |
| fld_busy | output | 4 | Per-field pending-result flags |
| inflight | output | 4 | Count of issued, ungraduated instructions |

## Verification
`iss_ready` is combinational, so it is due in the same cycle as the offer. The bench samples it mid-cycle, after driving the payload shortly past the rising edge. The busy vectors and the in-flight count are registered and reflect an issue or a graduation pulse one edge later. Each expectation is therefore queued for the cycle after the stimulus that causes it. The latency checks offer the consumer continuously and expect refusals for exactly one or two cycles before the grant. The drain checks place the grant in the cycle after the last graduation pulse.

// File: rtl/sb_pkg.sv
package sb_pkg;

  typedef enum logic [1:0] {
    CLS_LOGIC  = 2'd0,
    CLS_ARITH  = 2'd1,
    CLS_SATRND = 2'd2,
    CLS_MULDIV = 2'd3
  } op_class_e;

  localparam int LAT_W = 2;

  // Value loaded into a countdown at issue: result latency minus one.
  function automatic logic [LAT_W-1:0] class_load(input op_class_e c);
    logic [LAT_W-1:0] v;
    case (c)
      CLS_LOGIC:  v = 2'd0;
      CLS_ARITH:  v = 2'd1;
      CLS_SATRND: v = 2'd2;
      default:    v = 2'd0;
    endcase
    return v;
  endfunction

  // Multiply-class results are interlocked by the multiply unit itself.
  function automatic logic class_tracked(input op_class_e c);
    return c != CLS_MULDIV;
  endfunction

endpackage

// File: rtl/sb_lat_cnt.sv
module sb_lat_cnt #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         busy
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/sb_inflight.sv
module sb_inflight #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          grad,
  input  logic          multi_wr_fire,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full,
  output logic          drain_hold
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] cnt_q, cnt_n;
  logic          hold_q, hold_n;
  logic          dec;

  assign dec = grad && (cnt_q != '0);

  always_comb begin
    cnt_n = cnt_q;
    case ({fire, dec})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
    hold_n = (hold_q || multi_wr_fire) && (cnt_n != '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      hold_q <= hold_n;
    end
  end

  assign count      = cnt_q;
  assign empty      = (cnt_q == '0);
  assign full       = (cnt_q == CMAX);
  assign drain_hold = hold_q;
endmodule

// File: rtl/sb_issue_ctl.sv
module sb_issue_ctl #(
  parameter int NREG = 32,
  parameter int NFLD = 4,
  localparam int TAGW = $clog2(NREG)
) (
  input  logic [TAGW-1:0] src0,
  input  logic [TAGW-1:0] src1,
  input  logic [NFLD-1:0] frd,
  input  logic [NFLD-1:0] fwr,
  input  logic [NREG-1:0] reg_busy,
  input  logic [NFLD-1:0] fld_busy,
  input  logic            empty,
  input  logic            full,
  input  logic            drain_hold,
  output logic            ready,
  output logic            multi_rd,
  output logic            multi_wr
);
  logic reg_hazard;
  logic fld_ok;

  // More than one bit set: clearing the lowest set bit leaves a nonzero value.
  assign multi_rd = (frd & (frd - 1'b1)) != '0;
  assign multi_wr = (fwr & (fwr - 1'b1)) != '0;

  always_comb begin
    reg_hazard = reg_busy[src0] || reg_busy[src1];
    if (multi_rd) fld_ok = empty;
    else          fld_ok = (frd & fld_busy) == '0;
    ready = !drain_hold && !full && !reg_hazard && fld_ok;
  end
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard #(
  parameter int NREG = 32,
  parameter int NFLD = 4,
  parameter int CW   = 4,
  localparam int TAGW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  output logic            iss_ready,
  input  logic [1:0]      iss_cls,
  input  logic [TAGW-1:0] iss_src0,
  input  logic [TAGW-1:0] iss_src1,
  input  logic [TAGW-1:0] iss_dst,
  input  logic            iss_dst_we,
  input  logic [NFLD-1:0] iss_frd,
  input  logic [NFLD-1:0] iss_fwr,
  input  logic            grad,
  output logic [NREG-1:0] reg_busy,
  output logic [NFLD-1:0] fld_busy,
  output logic [CW-1:0]   inflight
);
  import sb_pkg::*;

  op_class_e        cls;
  logic             fire;
  logic             tracked;
  logic [LAT_W-1:0] ld_val;
  logic             empty, full, drain_hold;
  logic             multi_rd, multi_wr;

  assign cls     = op_class_e'(iss_cls);
  assign fire    = iss_valid && iss_ready;
  assign tracked = class_tracked(cls);
  assign ld_val  = class_load(cls);

  // Register countdowns; register 0 is hard-wired idle.
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == 0) begin : g_zero
      assign reg_busy[i] = 1'b0;
    end else begin : g_cnt
      logic ld;
      assign ld = fire && tracked && iss_dst_we && (iss_dst == TAGW'(i));
      sb_lat_cnt #(.W(LAT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .busy     (reg_busy[i])
      );
    end
  end

  // Control-register fields, each its own pseudo-register.
  for (genvar f = 0; f < NFLD; f++) begin : g_fld
    logic ld;
    assign ld = fire && tracked && iss_fwr[f];
    sb_lat_cnt #(.W(LAT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .busy     (fld_busy[f])
    );
  end

  sb_inflight #(.CW(CW)) u_infl (
    .clk           (clk),
    .rst_n         (rst_n),
    .fire          (fire),
    .grad          (grad),
    .multi_wr_fire (fire && multi_wr),
    .count         (inflight),
    .empty         (empty),
    .full          (full),
    .drain_hold    (drain_hold)
  );

  sb_issue_ctl #(.NREG(NREG), .NFLD(NFLD)) u_ctl (
    .src0       (iss_src0),
    .src1       (iss_src1),
    .frd        (iss_frd),
    .fwr        (iss_fwr),
    .reg_busy   (reg_busy),
    .fld_busy   (fld_busy),
    .empty      (empty),
    .full       (full),
    .drain_hold (drain_hold),
    .ready      (iss_ready),
    .multi_rd   (multi_rd),
    .multi_wr   (multi_wr)
  );
endmodule

// File: rtl/sb_chk.sv
module sb_chk #(
  parameter int NREG = 32,
  parameter int NFLD = 4,
  parameter int CW   = 4,
  localparam int TAGW = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            iss_valid,
  input logic            iss_ready,
  input logic [1:0]      iss_cls,
  input logic [TAGW-1:0] iss_src0,
  input logic [TAGW-1:0] iss_src1,
  input logic [TAGW-1:0] iss_dst,
  input logic            iss_dst_we,
  input logic [NFLD-1:0] iss_frd,
  input logic [NFLD-1:0] iss_fwr,
  input logic            grad,
  input logic [NREG-1:0] reg_busy,
  input logic [NFLD-1:0] fld_busy,
  input logic [CW-1:0]   inflight
);
  logic fire;
  assign fire = iss_valid && iss_ready;

  a_r1_src_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && reg_busy[iss_src0]) |-> !iss_ready);

  a_r2_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && iss_cls == 2'd0 && iss_dst_we) |=> !reg_busy[$past(iss_dst)]);

  a_r3_one_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && iss_cls == 2'd1 && iss_dst_we && iss_dst != '0) |=> reg_busy[$past(iss_dst)]);

  a_r4_two_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && iss_cls == 2'd2 && iss_dst_we && iss_dst != '0) |=> reg_busy[$past(iss_dst)]);

  a_r5_mul_untracked: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && iss_cls == 2'd3 && iss_dst_we && !reg_busy[iss_dst]) |=> !reg_busy[$past(iss_dst)]);

  a_r6_reg_zero: assert property (@(posedge clk) disable iff (!rst_n) !reg_busy[0]);

  a_r8_multi_read: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && $countones(iss_frd) > 1) |-> inflight == '0);

  a_r9_multi_write: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && $countones(iss_fwr) > 1) |=> !iss_ready);

  a_r10_full: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == {CW{1'b1}}) |-> !iss_ready);

  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !grad) |=> inflight == $past(inflight) + 1'b1);
endmodule

bind issue_scoreboard sb_chk #(.NREG(NREG), .NFLD(NFLD), .CW(CW)) u_chk (.*);

// File: tb/sim_issue_scoreboard.sv
module sim_issue_scoreboard;
  localparam int K_RDY = 0, K_BUSY = 1, K_FLD = 2, K_INF = 3;

  typedef struct {
    int          req;
    int          kind;
    logic [31:0] exp;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        iss_valid, iss_ready;
  logic [1:0]  iss_cls;
  logic [4:0]  iss_src0, iss_src1, iss_dst;
  logic        iss_dst_we;
  logic [3:0]  iss_frd, iss_fwr;
  logic        grad;
  logic [31:0] reg_busy;
  logic [3:0]  fld_busy;
  logic [3:0]  inflight;

  item_t q[$];
  int    checks = 0, errors = 0, mdl = 0;
  bit    done = 0;

  always #10 clk = ~clk;  // 50 MHz

  issue_scoreboard u0 (.*);

  task automatic drive(input logic v, input logic [1:0] c, input logic [4:0] s0, s1, d,
                       input logic we, input logic [3:0] rd, wr, input logic g);
    @(posedge clk); #2;
    iss_valid = v; iss_cls = c; iss_src0 = s0; iss_src1 = s1; iss_dst = d;
    iss_dst_we = we; iss_frd = rd; iss_fwr = wr; grad = g;
  endtask

  task automatic expect_item(input int req, input int kind, input logic [31:0] e);
    item_t it;
    it.req = req; it.kind = kind; it.exp = e;
    q.push_back(it);
  endtask

  task automatic idle();
    drive(0, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 0);
  endtask

  task automatic drain();
    while (mdl > 0) begin
      drive(0, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 1);
      mdl--;
    end
  endtask

  // Monitor: pops every expectation queued for this cycle.
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        K_RDY:   act = {31'd0, iss_ready};
        K_BUSY:  act = reg_busy;
        K_FLD:   act = {28'd0, fld_busy};
        default: act = {28'd0, inflight};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL R%0d kind %0d actual %0h expected %0h", it.req, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    iss_valid = 0; iss_cls = 0; iss_src0 = 0; iss_src1 = 0; iss_dst = 0;
    iss_dst_we = 0; iss_frd = 0; iss_fwr = 0; grad = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R11 reset state
    idle();
    expect_item(11, K_RDY, 1); expect_item(11, K_BUSY, 0);
    expect_item(11, K_FLD, 0); expect_item(11, K_INF, 0);

    // R3 arith latency 2; R1 refused offer changes nothing
    drive(1, 2'd1, 0, 0, 5, 1, 4'h0, 4'h0, 0); expect_item(1, K_RDY, 1); mdl++;
    drive(1, 2'd0, 5, 0, 0, 0, 4'h0, 4'h0, 0);
    expect_item(3, K_RDY, 0); expect_item(3, K_BUSY, 32'h20); expect_item(1, K_INF, 1);
    drive(1, 2'd0, 5, 0, 0, 0, 4'h0, 4'h0, 0); expect_item(3, K_RDY, 1); mdl++;
    idle(); expect_item(1, K_INF, 2);

    // R2 simple class, consumer next cycle
    drive(1, 2'd0, 0, 0, 6, 1, 4'h0, 4'h0, 0); expect_item(2, K_RDY, 1); mdl++;
    drive(1, 2'd0, 0, 6, 0, 0, 4'h0, 4'h0, 0);
    expect_item(2, K_RDY, 1); expect_item(2, K_BUSY, 0); mdl++;

    // R4 saturating class, latency 3
    drive(1, 2'd2, 0, 0, 7, 1, 4'h0, 4'h0, 0); expect_item(4, K_RDY, 1); mdl++;
    drive(1, 2'd0, 7, 0, 0, 0, 4'h0, 4'h0, 0);
    expect_item(4, K_RDY, 0); expect_item(4, K_BUSY, 32'h80);
    drive(1, 2'd0, 7, 0, 0, 0, 4'h0, 4'h0, 0);
    expect_item(4, K_RDY, 0); expect_item(4, K_BUSY, 32'h80);
    drive(1, 2'd0, 7, 0, 0, 0, 4'h0, 4'h0, 0); expect_item(4, K_RDY, 1); mdl++;

    // R5 multiply class untracked
    drive(1, 2'd3, 0, 0, 8, 1, 4'h0, 4'h0, 0); expect_item(5, K_RDY, 1); mdl++;
    drive(1, 2'd0, 8, 0, 0, 0, 4'h0, 4'h0, 0);
    expect_item(5, K_RDY, 1); expect_item(5, K_BUSY, 0); mdl++;

    // R6 register 0 never busy
    drive(1, 2'd1, 0, 0, 0, 1, 4'h0, 4'h0, 0); mdl++;
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 0);
    expect_item(6, K_RDY, 1); expect_item(6, K_BUSY, 0); mdl++;

    drain();
    idle(); expect_item(10, K_INF, 0);
    // R10 graduation at zero ignored
    drive(0, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 1);
    idle(); expect_item(10, K_INF, 0);

    // R7 per-field tracking
    drive(1, 2'd2, 0, 0, 0, 0, 4'h0, 4'h1, 0); expect_item(7, K_RDY, 1); mdl++;
    drive(1, 2'd0, 0, 0, 0, 0, 4'h2, 4'h0, 0);
    expect_item(7, K_RDY, 1); expect_item(7, K_FLD, 4'h1); mdl++;
    drive(1, 2'd0, 0, 0, 0, 0, 4'h1, 4'h0, 0); expect_item(7, K_RDY, 0);
    drive(1, 2'd0, 0, 0, 0, 0, 4'h1, 4'h0, 0); expect_item(7, K_RDY, 1); mdl++;

    // R8 multi-field read waits for empty
    drive(1, 2'd0, 0, 0, 0, 0, 4'h3, 4'h0, 0); expect_item(8, K_RDY, 0);
    drain();
    drive(1, 2'd0, 0, 0, 0, 0, 4'h3, 4'h0, 0);
    expect_item(8, K_RDY, 1); expect_item(8, K_INF, 0); mdl++;
    drain();

    // R9 multi-field write holds younger until graduated
    drive(1, 2'd1, 0, 0, 0, 0, 4'h0, 4'h6, 0); expect_item(9, K_RDY, 1); mdl++;
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 0); expect_item(9, K_RDY, 0);
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 0); expect_item(9, K_RDY, 0);
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 1); expect_item(9, K_RDY, 0); mdl--;
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 0); expect_item(9, K_RDY, 1); mdl++;
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h4, 0); expect_item(9, K_RDY, 1); mdl++;
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 0); expect_item(9, K_RDY, 1); mdl++;
    drain();

    // R10 full count and simultaneous issue/graduate
    for (int i = 0; i < 15; i++) begin
      drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 0); mdl++;
    end
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 0);
    expect_item(10, K_RDY, 0); expect_item(10, K_INF, 15);
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 1); expect_item(10, K_RDY, 0); mdl--;
    drive(1, 2'd0, 0, 0, 0, 0, 4'h0, 4'h0, 1);
    expect_item(10, K_RDY, 1); expect_item(10, K_INF, 14);
    idle(); expect_item(10, K_INF, 14);
    drain();
    idle(); expect_item(10, K_INF, 0); expect_item(11, K_BUSY, 0);

    idle();
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R1 watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule